// File: doc/BRIEF.md
# Received Signal Strength Estimator with Pulse-Width Output

This block takes a per-symbol amplitude estimate from the demodulator and turns it into a signal-strength level for the PN code acquisition and tracking logic. Each amplitude sample is shifted left by a programmable gain of 0 to 3 places. The result is clipped to an 8-bit value. It is then smoothed in one of two ways, chosen by an external track-on input.

With track-on low the block is in acquisition ("slip") mode. Every valid sample loads the level directly, so a short correlation peak reaches the output at once. With track-on high the block is in tracking mode. The level moves one eighth of the way toward each new sample, which gives the code loop a steady value.

The level sets the duty of a 256-clock pulse-width modulator. An external RC network turns the single output bit into an analogue voltage.

Top module: `rssi_strength_pwm`

## Requirements
- R1: While reset is asserted, and after it is released until a sample arrives, the level and the duty are 0 and the PWM output is low.
- R2: A sample is scaled as magnitude multiplied by 2^gain, where gain is the 2-bit value on `gain_i` (0 to 3).
- R3: A scaled value above 255 is clipped to 255.
- R4: In slip mode (`track_on_i` = 0), each cycle with `mag_vld_i` = 1 replaces the level with the scaled sample. The new level is visible one clock later.
- R5: In track mode (`track_on_i` = 1), each valid sample updates the level to level + floor((scaled − level) / 8).
- R6: In a cycle with `mag_vld_i` = 0, the level does not change, whatever the magnitude or gain inputs carry.
- R7: A free-running counter steps through 0..255. The output is high exactly while the counter is below the current duty, so a duty of D gives D high clocks in every 256.
- R8: The duty takes the value of the level only on the clock edge where the counter wraps from 255 to 0. A level change in the middle of a period does not alter that period.
- R9: Changing `track_on_i` without a valid sample leaves the level unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mag_i | input | 8 | Per-symbol amplitude estimate |
| mag_vld_i | input | 1 | Strobe marking a new amplitude sample |
| track_on_i | input | 1 | 0 = slip (acquisition) mode, 1 = track mode |
| gain_i | input | 2 | Left-shift amount applied to each sample |
| pwm_o | output | 1 | Pulse-width modulated strength output |

## Verification
Every internal register of this block can be seen only through the duty of `pwm_o`, so a wrong level shows up with a delay. A wrong sample reaches the output at the next counter wrap, which is up to 256 clocks later. It then shows as a different count of high cycles within one period. A wrong counter or duty register shows up within a single period, as an edge in the wrong cycle. The bench therefore compares `pwm_o` against its own model on every clock. It also counts the high cycles in whole periods, so that an error in the boundary timing or in the rounding of the average is pinned to one period.

// File: rtl/rssi_pkg.sv
package rssi_pkg;

  // Multiply a magnitude by 2^shift and clip it at maxv.
  function automatic int unsigned scale_clip(input int unsigned mag,
                                             input int unsigned shift,
                                             input int unsigned maxv);
    longint unsigned wide;
    wide = longint'(mag) << shift;
    if (wide > longint'(maxv)) return maxv;
    return int'(wide);
  endfunction

  // One step of the exponential average: move by (sample-level) >>> k.
  // The arithmetic shift rounds toward minus infinity.
  function automatic int ema_move(input int level, input int sample,
                                  input int unsigned k);
    int diff;
    diff = sample - level;
    return level + (diff >>> k);
  endfunction

endpackage

// File: rtl/rssi_scale.sv
module rssi_scale #(
  parameter int MAG_W  = 8,
  parameter int GAIN_W = 2,
  parameter int DUTY_W = 8
) (
  input  logic [MAG_W-1:0]  mag_i,
  input  logic [GAIN_W-1:0] gain_i,
  output logic [DUTY_W-1:0] scaled_o,
  output logic              clipped_o
);
  import rssi_pkg::*;

  localparam int unsigned MAXV = (1 << DUTY_W) - 1;

  logic [31:0] raw;

  always_comb begin
    raw       = 32'(scale_clip(32'(mag_i), 32'(gain_i), MAXV));
    scaled_o  = raw[DUTY_W-1:0];
    clipped_o = ((32'(mag_i) << gain_i) > MAXV);
  end

  // A clipped sample must read as full scale.
  always_comb begin
    if (clipped_o) begin
      AST_CLIP_FULL: assert (scaled_o == DUTY_W'(MAXV)); // R3
    end
  end

endmodule

// File: rtl/rssi_smooth.sv
module rssi_smooth #(
  parameter int DUTY_W    = 8,
  parameter int EMA_SHIFT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vld_i,
  input  logic              track_i,
  input  logic [DUTY_W-1:0] sample_i,
  output logic [DUTY_W-1:0] level_o,
  output logic              slip_load_o,
  output logic              track_step_o
);
  import rssi_pkg::*;

  logic [DUTY_W-1:0] level_q;
  logic [DUTY_W-1:0] level_d;
  logic [31:0]       ema_res;

  assign slip_load_o  = vld_i & ~track_i;
  assign track_step_o = vld_i &  track_i;

  always_comb begin
    ema_res = 32'(ema_move(int'(level_q), int'(sample_i), EMA_SHIFT));
    level_d = level_q;
    if (slip_load_o)       level_d = sample_i;
    else if (track_step_o) level_d = ema_res[DUTY_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= '0;
    else        level_q <= level_d;
  end

  assign level_o = level_q;

  AST_HOLD_NO_VLD: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_i |=> $stable(level_q)); // R6
  AST_SLIP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    slip_load_o |=> level_q == $past(sample_i)); // R4
  AST_TRACK_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (track_step_o && sample_i >= level_q) |=>
      (level_q >= $past(level_q) && level_q <= $past(sample_i))); // R5
  AST_TRACK_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (track_step_o && sample_i < level_q) |=>
      (level_q < $past(level_q) && level_q >= $past(sample_i))); // R5

endmodule

// File: rtl/rssi_pwm_gen.sv
module rssi_pwm_gen #(
  parameter int DUTY_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DUTY_W-1:0] level_i,
  output logic              pwm_o,
  output logic              wrap_o
);
  logic [DUTY_W-1:0] cnt_q;
  logic [DUTY_W-1:0] duty_q;

  assign wrap_o = (cnt_q == '1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      duty_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
      if (wrap_o) duty_q <= level_i;
    end
  end

  assign pwm_o = (cnt_q < duty_q);

  AST_DUTY_ONLY_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap_o |=> $stable(duty_q)); // R8
  AST_DUTY_TAKES_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_o |=> duty_q == $past(level_i)); // R8
  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_o |=> cnt_q == '0); // R7
  AST_ZERO_DUTY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_q == '0) |-> !pwm_o); // R7

endmodule

// File: rtl/rssi_strength_pwm.sv
module rssi_strength_pwm #(
  parameter int MAG_W     = 8,
  parameter int GAIN_W    = 2,
  parameter int DUTY_W    = 8,
  parameter int EMA_SHIFT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MAG_W-1:0]  mag_i,
  input  logic              mag_vld_i,
  input  logic              track_on_i,
  input  logic [GAIN_W-1:0] gain_i,
  output logic              pwm_o
);
  logic [DUTY_W-1:0] scaled;
  logic              clipped;
  logic [DUTY_W-1:0] level;
  logic              slip_load;
  logic              track_step;
  logic              wrap;

  rssi_scale #(.MAG_W(MAG_W), .GAIN_W(GAIN_W), .DUTY_W(DUTY_W)) u_scale (
    .mag_i     (mag_i),
    .gain_i    (gain_i),
    .scaled_o  (scaled),
    .clipped_o (clipped)
  );

  rssi_smooth #(.DUTY_W(DUTY_W), .EMA_SHIFT(EMA_SHIFT)) u_smooth (
    .clk          (clk),
    .rst_n        (rst_n),
    .vld_i        (mag_vld_i),
    .track_i      (track_on_i),
    .sample_i     (scaled),
    .level_o      (level),
    .slip_load_o  (slip_load),
    .track_step_o (track_step)
  );

  rssi_pwm_gen #(.DUTY_W(DUTY_W)) u_pwm (
    .clk     (clk),
    .rst_n   (rst_n),
    .level_i (level),
    .pwm_o   (pwm_o),
    .wrap_o  (wrap)
  );

  AST_MODE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({slip_load, track_step})); // R9
  AST_SCALE_NO_SHRINK: assert property (@(posedge clk) disable iff (!rst_n)
    !clipped |-> scaled >= DUTY_W'(mag_i)); // R2

endmodule

// File: tb/rssi_strength_pwm_bench.sv
`timescale 1ns/1ps
module rssi_strength_pwm_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] mag = '0;
  logic       vld = 1'b0;
  logic       trk = 1'b0;
  logic [1:0] gain = '0;
  logic       pwm;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // model state
  int m_cnt = 0, m_duty = 0, m_level = 0;

  always #4 clk = ~clk;

  rssi_strength_pwm u_rssi_strength_pwm (
    .clk(clk), .rst_n(rst_n), .mag_i(mag), .mag_vld_i(vld),
    .track_on_i(trk), .gain_i(gain), .pwm_o(pwm)
  );

  function automatic int b_scale(input int m, input int g);
    int v;
    v = m * (2 ** g);
    return (v > 255) ? 255 : v;
  endfunction

  function automatic int b_track(input int lvl, input int s);
    int d;
    d = s - lvl;
    if (d >= 0) return lvl + d / 8;
    return lvl - ((-d + 7) / 8);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt <= 0; m_duty <= 0; m_level <= 0;
    end else begin
      if (m_cnt == 255) m_duty <= m_level;
      m_cnt <= (m_cnt + 1) % 256;
      if (vld) m_level <= trk ? b_track(m_level, b_scale(mag, gain))
                              : b_scale(mag, gain);
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // every-cycle comparison against the model: R7 R8
  always @(negedge clk) begin
    if (rst_n && !done) check("R7 pwm per cycle", int'(pwm), (m_cnt < m_duty) ? 1 : 0);
  end

  task automatic to_period_start();
    do @(negedge clk); while (m_cnt != 0);
  endtask

  // count high cycles over one full period starting at counter 0
  task automatic count_period(output int highs);
    highs = 0;
    to_period_start();
    for (int i = 0; i < 256; i++) begin
      if (pwm) highs++;
      @(negedge clk);
    end
  endtask

  task automatic sample(input int m, input int g, input bit t);
    @(negedge clk);
    mag = 8'(m); gain = 2'(g); trk = t; vld = 1'b1;
    @(negedge clk);
    vld = 1'b0; mag = 8'($urandom); gain = 2'($urandom);
  endtask

  task automatic settle_and_count(input string req, input int exp);
    int h;
    to_period_start();
    count_period(h);
    check(req, h, exp);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    #(200000 * 8);
    n_bad++;
    $display("FAIL watchdog expired");
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    int h, lvl, exp;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    check("R1 pwm low in reset", int'(pwm), 0);
    rst_n = 1'b1;
    count_period(h);
    check("R1 no highs after reset", h, 0);

    // R2 gain scaling, slip mode
    sample(20, 2, 1'b0);
    settle_and_count("R2 mag20 gain2", 80);
    sample(33, 0, 1'b0);
    settle_and_count("R2 mag33 gain0", 33);
    sample(17, 3, 1'b0);
    settle_and_count("R2 mag17 gain3", 136);

    // R3 saturation
    sample(255, 3, 1'b0);
    settle_and_count("R3 clip full", 255);
    sample(129, 1, 1'b0);
    settle_and_count("R3 clip 258", 255);

    // R4 slip: direct replace, several samples, last wins
    sample(200, 0, 1'b0);
    sample(5, 0, 1'b0);
    settle_and_count("R4 slip last sample", 5);

    // R6 no valid: junk on inputs ignored
    for (int i = 0; i < 300; i++) begin
      @(negedge clk); mag = 8'($urandom); gain = 2'($urandom);
    end
    settle_and_count("R6 hold without valid", 5);

    // R9 toggle mode without valid
    @(negedge clk); trk = 1'b1;
    repeat (10) @(negedge clk);
    trk = 1'b0;
    settle_and_count("R9 mode toggle holds", 5);

    // R5 track: from 5 toward 200
    lvl = 5;
    for (int i = 0; i < 4; i++) begin
      sample(200, 0, 1'b1);
      lvl = b_track(lvl, 200);
    end
    settle_and_count("R5 track up", lvl);
    // downward step with floor rounding
    sample(0, 0, 1'b1);
    lvl = b_track(lvl, 0);
    settle_and_count("R5 track down floor", lvl);
    // small negative difference still moves by one
    sample(lvl - 1, 0, 1'b1);
    lvl = lvl - 1;
    settle_and_count("R5 track diff minus one", lvl);
    // small positive difference does not move
    sample(lvl + 7, 0, 1'b1);
    settle_and_count("R5 track diff plus seven", lvl);

    // R8 mid-period change does not affect current period
    to_period_start();
    exp = lvl;
    h = 0;
    for (int i = 0; i < 256; i++) begin
      if (pwm) h++;
      if (i == 100) begin vld = 1'b1; mag = 8'd250; gain = 2'd0; trk = 1'b0; end
      else vld = 1'b0;
      @(negedge clk);
    end
    check("R8 mid-period update deferred", h, exp);
    count_period(h);
    check("R8 new duty next period", h, 250);

    // random mix, compared every cycle by the model
    for (int i = 0; i < 6000; i++) begin
      @(negedge clk);
      vld  = ($urandom % 4) == 0;
      mag  = 8'($urandom);
      gain = 2'($urandom);
      if (($urandom % 64) == 0) trk = ~trk;
    end
    vld = 1'b0;
    repeat (600) @(negedge clk);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule